// File: doc/BRIEF.md
# Reset Sequencer with Boot-Mode Latch

This block turns several reset causes into one clean reset for the processor core. An active-low external reset pin, together with reset requests from the watchdog, the brownout detector and the PLL-loss monitor, holds the core in reset. The core leaves reset only after the PLL reports lock and a programmable number of settling cycles has passed. Assertion from the external pin is asynchronous. Release is always synchronous to the clock.

When a valid external reset ends, the block samples two strap pins and latches the chip operating mode. The strap pins are the mode strap and the serial-transmit line. An external reset counts as valid when it was held low long enough. Resets caused only by internal sources, and external pulses that are too short, restart the core but keep the latched mode. Once the core is running, an output-enable is raised so that the mode strap pin can be used as a driven output.

Top module: `boot_reset_ctrl`

## Requirements
- R1: While `ext_rst_n` is low, `cpu_rst` is 1. A falling edge on `ext_rst_n` sets `cpu_rst` at once, without waiting for a clock edge, and this works at any time, including during normal operation.
- R2: If `wdt_rst_req`, `bod_rst_req` or `pll_loss_req` is 1 at a rising clock edge, `cpu_rst` is 1 right after that edge. It stays 1 for as long as any of these requests is high.
- R3: `cpu_rst` never falls while `pll_locked` is low, even when every reset source is inactive.
- R4: `cpu_rst` falls exactly `EXTRA_CYCLES` clock edges after the first edge at which the block is waiting for lock and sees `pll_locked` high. If lock drops during that stretch, the count starts again from the next edge that sees lock.
- R5: An external low lasting at least `MIN_LOW_CYCLES` synchronized cycles is valid. When it ends, a high mode strap latches `boot_mode` = 2'b00 (normal).
- R6: When a valid external reset ends with the mode strap low and the transmit strap high, `boot_mode` = 2'b01 (bootstrap load).
- R7: When a valid external reset ends with both straps low, `boot_mode` = 2'b10 (test). The code 2'b11 is never produced.
- R8: An external low shorter than `MIN_LOW_CYCLES - 2` clock periods restarts the core (R1) but leaves `boot_mode` unchanged.
- R9: Resets from internal requests never change `boot_mode`. `boot_mode` changes only while `cpu_rst` is 1.
- R10: `strap_oe` is 0 whenever `cpu_rst` is 1. It becomes 1 on the same edge at which `cpu_rst` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| wdt_rst_req | input | 1 | Watchdog reset request, synchronous to clk |
| bod_rst_req | input | 1 | Brownout reset request, synchronous to clk |
| pll_loss_req | input | 1 | PLL-loss reset request, synchronous to clk |
| pll_locked | input | 1 | PLL lock indication |
| strap_mode_in | input | 1 | Mode strap pin level (high = normal) |
| strap_txd_in | input | 1 | Serial-transmit pin level, used to select test mode |
| cpu_rst | output | 1 | Core reset, active high |
| boot_mode | output | 2 | Latched mode: 00 normal, 01 bootstrap, 10 test |
| strap_oe | output | 1 | Output-enable for the mode strap pin after release |

## Verification
The bench times the exact release edge after lock rises. It also drops lock partway through the settling stretch. A design that counted from the source release instead, or that did not restart its count, would release the core early.

External pulses are sent on both sides of the length threshold, with the straps set to a mode that differs from the one already latched. A design that re-sampled the mode on every reset, or on internal-only resets, would then show the wrong code.

Each of the three internal requests is raised while the core is running, to confirm that reset returns on the next edge. The output-enable is checked against the reset at every release.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

    typedef enum logic [1:0] {
        MODE_NORMAL = 2'b00,
        MODE_BOOT   = 2'b01,
        MODE_TEST   = 2'b10
    } boot_mode_e;

    typedef enum logic [1:0] {
        SQ_HOLD,
        SQ_LOCKWAIT,
        SQ_STRETCH,
        SQ_RUN
    } seq_state_e;

    function automatic boot_mode_e decode_straps(input logic mode_pin, input logic txd_pin);
        if (mode_pin)
            return MODE_NORMAL;
        else if (txd_pin)
            return MODE_BOOT;
        else
            return MODE_TEST;
    endfunction

endpackage

// File: rtl/rstseq_sync.sv
// Multi-stage synchronizer, cleared asynchronously by the raw reset pin.
module rstseq_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [STAGES-1:0][WIDTH-1:0] chain_d;
    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    always_comb begin
        chain_d[0] = din;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_comb begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n)
            chain_q <= '0;
        else
            chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/rstseq_strap.sv
// Measures the synchronized external low time and latches the mode
// from the straps when a long enough low ends.
module rstseq_strap
    import rstseq_pkg::*;
#(
    parameter int MIN_LOW_CYCLES = 8
) (
    input  logic       clk,
    input  logic       ext_s,
    input  logic       mode_s,
    input  logic       txd_s,
    output boot_mode_e mode
);

    localparam int CW = $clog2(MIN_LOW_CYCLES + 1);
    localparam logic [CW-1:0] LOW_SAT = CW'(MIN_LOW_CYCLES);

    typedef struct packed {
        logic          ext_prev;
        logic [CW-1:0] low_cnt;
        boot_mode_e    mode;
    } strap_st_t;

    strap_st_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.ext_prev = ext_s;
        if (!ext_s) begin
            if (st_q.low_cnt != LOW_SAT)
                st_d.low_cnt = st_q.low_cnt + 1'b1;
        end else begin
            st_d.low_cnt = '0;
            if (!st_q.ext_prev && st_q.low_cnt == LOW_SAT)
                st_d.mode = decode_straps(mode_s, txd_s);
        end
    end

    // Deliberately not cleared by the pin, so short glitches keep the mode.
    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign mode = st_q.mode;

endmodule

// File: rtl/rstseq_fsm.sv
// Release sequencer: hold -> wait for lock -> settle -> run.
module rstseq_fsm
    import rstseq_pkg::*;
#(
    parameter int EXTRA_CYCLES = 16
) (
    input  logic clk,
    input  logic arst_n,
    input  logic ext_s,
    input  logic int_req,
    input  logic pll_locked,
    output logic cpu_rst,
    output logic strap_oe
);

    localparam int CW = $clog2(EXTRA_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(EXTRA_CYCLES - 1);

    typedef struct packed {
        seq_state_e    st;
        logic [CW-1:0] cnt;
        logic          rst;
        logic          oe;
    } seq_t;

    seq_t sq_d, sq_q;

    always_comb begin
        sq_d = sq_q;
        unique case (sq_q.st)
            SQ_HOLD: begin
                sq_d.st  = SQ_LOCKWAIT;
                sq_d.cnt = '0;
            end
            SQ_LOCKWAIT: begin
                if (pll_locked) begin
                    sq_d.st  = SQ_STRETCH;
                    sq_d.cnt = '0;
                end
            end
            SQ_STRETCH: begin
                if (!pll_locked)
                    sq_d.st = SQ_LOCKWAIT;
                else if (sq_q.cnt == LAST)
                    sq_d.st = SQ_RUN;
                else
                    sq_d.cnt = sq_q.cnt + 1'b1;
            end
            default: sq_d.st = SQ_RUN;
        endcase
        if (!ext_s || int_req) begin
            sq_d.st  = SQ_HOLD;
            sq_d.cnt = '0;
        end
        sq_d.rst = (sq_d.st != SQ_RUN);
        sq_d.oe  = (sq_d.st == SQ_RUN);
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            sq_q.st  <= SQ_HOLD;
            sq_q.cnt <= '0;
            sq_q.rst <= 1'b1;
            sq_q.oe  <= 1'b0;
        end else begin
            sq_q <= sq_d;
        end
    end

    assign cpu_rst  = sq_q.rst;
    assign strap_oe = sq_q.oe;

endmodule

// File: rtl/boot_reset_ctrl.sv
module boot_reset_ctrl
    import rstseq_pkg::*;
#(
    parameter int MIN_LOW_CYCLES = 8,
    parameter int EXTRA_CYCLES   = 16,
    parameter int SYNC_STAGES    = 2
) (
    input  logic       clk,
    input  logic       ext_rst_n,
    input  logic       wdt_rst_req,
    input  logic       bod_rst_req,
    input  logic       pll_loss_req,
    input  logic       pll_locked,
    input  logic       strap_mode_in,
    input  logic       strap_txd_in,
    output logic       cpu_rst,
    output logic [1:0] boot_mode,
    output logic       strap_oe
);

    localparam int PINS = 3;

    logic [PINS-1:0] pins_raw;
    logic [PINS-1:0] pins_s;
    logic            int_req;
    boot_mode_e      mode_q;

    assign pins_raw = {strap_txd_in, strap_mode_in, ext_rst_n};
    assign int_req  = wdt_rst_req | bod_rst_req | pll_loss_req;

    rstseq_sync #(.WIDTH(PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .clr_n (ext_rst_n),
        .din   (pins_raw),
        .dout  (pins_s)
    );

    rstseq_strap #(.MIN_LOW_CYCLES(MIN_LOW_CYCLES)) u_strap (
        .clk    (clk),
        .ext_s  (pins_s[0]),
        .mode_s (pins_s[1]),
        .txd_s  (pins_s[2]),
        .mode   (mode_q)
    );

    rstseq_fsm #(.EXTRA_CYCLES(EXTRA_CYCLES)) u_fsm (
        .clk        (clk),
        .arst_n     (ext_rst_n),
        .ext_s      (pins_s[0]),
        .int_req    (int_req),
        .pll_locked (pll_locked),
        .cpu_rst    (cpu_rst),
        .strap_oe   (strap_oe)
    );

    assign boot_mode = mode_q;

endmodule

// File: rtl/rstseq_chk.sv
module rstseq_chk #(
    parameter int EXTRA_CYCLES = 16
) (
    input logic       clk,
    input logic       ext_rst_n,
    input logic       wdt_rst_req,
    input logic       bod_rst_req,
    input logic       pll_loss_req,
    input logic       pll_locked,
    input logic       cpu_rst,
    input logic [1:0] boot_mode,
    input logic       strap_oe
);

    logic [31:0] lock_run_q;

    always_ff @(posedge clk or negedge ext_rst_n) begin
        if (!ext_rst_n)
            lock_run_q <= '0;
        else if (!pll_locked)
            lock_run_q <= '0;
        else if (lock_run_q <= 32'(EXTRA_CYCLES))
            lock_run_q <= lock_run_q + 1;
    end

    AST_EXT_HOLDS_RESET: assert property (@(posedge clk) !ext_rst_n |-> cpu_rst); // R1
    AST_INT_REQ_RESET: assert property (@(posedge clk) disable iff (!ext_rst_n)
        (wdt_rst_req || bod_rst_req || pll_loss_req) |=> cpu_rst); // R2
    AST_NO_UNLOCKED_RELEASE: assert property (@(posedge clk) disable iff (!ext_rst_n)
        $fell(cpu_rst) |-> $past(pll_locked)); // R3
    AST_LOCK_STRETCH: assert property (@(posedge clk) disable iff (!ext_rst_n)
        $fell(cpu_rst) |-> (lock_run_q >= 32'(EXTRA_CYCLES))); // R4
    AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!ext_rst_n)
        boot_mode != 2'b11); // R7
    AST_MODE_ONLY_IN_RESET: assert property (@(posedge clk) disable iff (!ext_rst_n)
        !$stable(boot_mode) |-> cpu_rst); // R9
    AST_OE_OFF_IN_RESET: assert property (@(posedge clk) disable iff (!ext_rst_n)
        cpu_rst |-> !strap_oe); // R10
    AST_OE_ON_RELEASE: assert property (@(posedge clk) disable iff (!ext_rst_n)
        $fell(cpu_rst) |-> strap_oe); // R10

endmodule

bind boot_reset_ctrl rstseq_chk #(.EXTRA_CYCLES(EXTRA_CYCLES)) u_chk (
    .clk          (clk),
    .ext_rst_n    (ext_rst_n),
    .wdt_rst_req  (wdt_rst_req),
    .bod_rst_req  (bod_rst_req),
    .pll_loss_req (pll_loss_req),
    .pll_locked   (pll_locked),
    .cpu_rst      (cpu_rst),
    .boot_mode    (boot_mode),
    .strap_oe     (strap_oe)
);

// File: tb/boot_reset_ctrl_bench.sv
`timescale 1ns/100ps
module boot_reset_ctrl_bench;

    localparam int MIN_LOW = 8;
    localparam int EXTRA   = 16;

    logic       clk = 1'b0;
    logic       ext_rst_n = 1'b1;
    logic       wdt_rst_req = 1'b0;
    logic       bod_rst_req = 1'b0;
    logic       pll_loss_req = 1'b0;
    logic       pll_locked = 1'b0;
    logic       strap_mode_in = 1'b1;
    logic       strap_txd_in = 1'b1;
    logic       cpu_rst;
    logic [1:0] boot_mode;
    logic       strap_oe;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;
    logic [1:0] exp_mode = 2'b00;

    always #2 clk = ~clk;

    boot_reset_ctrl #(.MIN_LOW_CYCLES(MIN_LOW), .EXTRA_CYCLES(EXTRA)) u_boot_reset_ctrl (
        .clk(clk), .ext_rst_n(ext_rst_n), .wdt_rst_req(wdt_rst_req),
        .bod_rst_req(bod_rst_req), .pll_loss_req(pll_loss_req),
        .pll_locked(pll_locked), .strap_mode_in(strap_mode_in),
        .strap_txd_in(strap_txd_in), .cpu_rst(cpu_rst),
        .boot_mode(boot_mode), .strap_oe(strap_oe)
    );

    function automatic logic [1:0] model_mode(input logic m, input logic t);
        if (m) return 2'b00;
        if (t) return 2'b01;
        return 2'b10;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // count negedges with cpu_rst high until it falls
    task automatic wait_release(output int n);
        n = 0;
        forever begin
            @(negedge clk);
            if (!cpu_rst) break;
            n++;
            if (n > 400) break;
        end
    endtask

    task automatic ext_pulse(input int w);
        @(posedge clk); #1;
        ext_rst_n = 1'b0;
        #0.5;
        check(cpu_rst == 1'b1, "R1 async assert", cpu_rst, 1);
        repeat (w) @(posedge clk);
        #1;
        ext_rst_n = 1'b1;
    endtask

    task automatic pulse_req(input int which, input int len);
        int n;
        @(posedge clk); #1;
        case (which)
            0: wdt_rst_req = 1'b1;
            1: bod_rst_req = 1'b1;
            default: pll_loss_req = 1'b1;
        endcase
        @(posedge clk);
        @(negedge clk);
        check(cpu_rst == 1'b1, "R2 request asserts reset", cpu_rst, 1);
        check(strap_oe == 1'b0, "R10 oe low in reset", strap_oe, 0);
        repeat (len) @(negedge clk);
        check(cpu_rst == 1'b1, "R2 reset held by request", cpu_rst, 1);
        @(posedge clk); #1;
        wdt_rst_req = 1'b0; bod_rst_req = 1'b0; pll_loss_req = 1'b0;
        wait_release(n);
        check(n <= EXTRA + 8, "R2 release after request", n, EXTRA + 8);
        check(boot_mode == exp_mode, "R9 mode kept on internal reset", boot_mode, exp_mode);
    endtask

    initial begin
        int n;
        void'($urandom(32'd20240611));
        #1 ext_rst_n = 1'b0;
        #0.5;
        check(cpu_rst == 1'b1, "R1 reset state", cpu_rst, 1);
        check(strap_oe == 1'b0, "R10 reset state oe", strap_oe, 0);
        step(20);
        ext_rst_n = 1'b1;
        exp_mode = model_mode(1'b1, 1'b1);
        step(40);
        check(cpu_rst == 1'b1, "R3 held while unlocked", cpu_rst, 1);
        pll_locked = 1'b1;
        wait_release(n);
        check(n == EXTRA + 1, "R4 stretch length", n, EXTRA + 1);
        check(boot_mode == 2'b00, "R5 normal mode", boot_mode, 0);
        check(strap_oe == 1'b1, "R10 oe after release", strap_oe, 1);

        for (int k = 0; k < 3; k++) pulse_req(k, 4);

        strap_mode_in = 1'b0; strap_txd_in = 1'b1;
        ext_pulse(MIN_LOW + 6);
        exp_mode = 2'b01;
        wait_release(n);
        check(boot_mode == 2'b01, "R6 bootstrap mode", boot_mode, 1);

        strap_mode_in = 1'b0; strap_txd_in = 1'b0;
        ext_pulse(MIN_LOW + 6);
        exp_mode = 2'b10;
        wait_release(n);
        check(boot_mode == 2'b10, "R7 test mode", boot_mode, 2);

        strap_mode_in = 1'b1; strap_txd_in = 1'b1;
        ext_pulse(MIN_LOW + 6);
        exp_mode = 2'b00;
        wait_release(n);
        check(boot_mode == 2'b00, "R5 back to normal", boot_mode, 0);

        strap_mode_in = 1'b0; strap_txd_in = 1'b0;
        ext_pulse(2);
        wait_release(n);
        check(boot_mode == 2'b00, "R8 short pulse keeps mode", boot_mode, 0);
        check(strap_oe == 1'b1, "R10 oe after short pulse", strap_oe, 1);

        // lock lost during the settling stretch
        strap_mode_in = 1'b1; strap_txd_in = 1'b1;
        pll_locked = 1'b0;
        ext_pulse(MIN_LOW + 6);
        step(30);
        pll_locked = 1'b1;
        step(4);
        pll_locked = 1'b0;
        @(negedge clk);
        check(cpu_rst == 1'b1, "R3 no release on lock drop", cpu_rst, 1);
        @(posedge clk); #1;
        pll_locked = 1'b1;
        wait_release(n);
        check(n == EXTRA + 1, "R4 stretch restarts", n, EXTRA + 1);

        for (int it = 0; it < 40; it++) begin
            logic m, t;
            bit lng;
            int w;
            m = 1'($urandom % 2);
            t = 1'($urandom % 2);
            lng = ($urandom % 3) != 0;
            w = lng ? (MIN_LOW + 4 + int'($urandom % 10)) : (1 + int'($urandom % (MIN_LOW - 4)));
            strap_mode_in = m; strap_txd_in = t;
            ext_pulse(w);
            if (lng) exp_mode = model_mode(m, t);
            wait_release(n);
            check(n <= EXTRA + 8, "R4 random release bound", n, EXTRA + 8);
            check(boot_mode == exp_mode, lng ? "R5 random latch" : "R8 random glitch", boot_mode, exp_mode);
            strap_mode_in = 1'($urandom % 2); strap_txd_in = 1'($urandom % 2);
            if ($urandom % 2 == 1) pulse_req(int'($urandom % 3), 1 + int'($urandom % 5));
            step(int'($urandom % 6));
        end

        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog timeout actual=%0d expected=%0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule